// File: doc/BRIEF.md
# Pipelined Square-Matrix Multiply Engine

This block computes the product C = A x B of two square N x N matrices. A and B hold signed 8-bit elements and C receives 16-bit elements. Each matrix lives in its own external single-port memory. The engine drives each memory through an address, a chip enable and a one-cycle-latency read-data port, and it also drives a write enable and write data on the C memory. Elements sit in row-major order, so element (row, col) is at word row*N + col.

A one-cycle start pulse, given while the engine is idle, launches a run. The engine walks the index space with the row index outermost, then the column index, then the summation index k. A one-cycle done pulse marks the end of the run. The parameter `LOCAL_ACC` selects one of two schedules:

- **Read-modify-write (`LOCAL_ACC` = 0):** each k step reads the partial sum from C and writes it back. Because of this, one k step issues only every third cycle.
- **Register accumulation (`LOCAL_ACC` = 1):** the partial sum stays in a register that feeds itself. A and B are read every cycle, and each C element is written once.

Top module: `mmx_engine`

## Requirements
- R1: After reset, `idle` is 1, `done` is 0, and `a_ce`, `b_ce` and `c_ce` are 0.
- R2: After a run, every C word at address r*N+c holds the sum over k of A[r*N+k]*B[k*N+c]. Whatever the C memory held before the run has no effect on the result.
- R3: A `start` pulse given while `idle` is 0 is ignored: the run in progress keeps its timing and its result, and `done` pulses only once.
- R4: `done` is high for exactly one cycle. That cycle is the one directly after the cycle that writes C address N*N-1.
- R5: In read-modify-write mode, each k step takes three cycles: an A/B read, then a C read, then a C write. The final C write comes 3*N^3 cycles after the cycle in which `start` is sampled, so `done` is seen 3*N^3 clock edges after that start edge.
- R6: In read-modify-write mode, `c_we` is never high without `c_ce`, and an A/B read never follows another A/B read in the next cycle. A run makes N^3 A/B reads, N^3 C reads and N^3 C writes.
- R7: In register-accumulation mode, the engine reads A and B on N^3 consecutive cycles, never reads C, and writes each C element exactly once (N*N writes). `done` is seen N^3+2 clock edges after the start edge.
- R8: Elements and products are treated as two's-complement values. Each product is sign-extended to 16 bits, and sums wrap modulo 2^16.
- R9: While `idle` is 1, no memory chip enable is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run when sampled high while idle |
| idle | output | 1 | High when no run or pipeline drain is in progress |
| done | output | 1 | One-cycle pulse after the final C write |
| a_addr | output | MAW | Word address into the A memory |
| a_ce | output | 1 | Read enable of the A memory |
| a_q | input | EW | A read data, valid one cycle after `a_ce` |
| b_addr | output | MAW | Word address into the B memory |
| b_ce | output | 1 | Read enable of the B memory |
| b_q | input | EW | B read data, valid one cycle after `b_ce` |
| c_addr | output | MAW | Word address into the C memory |
| c_ce | output | 1 | Access enable of the C memory |
| c_we | output | 1 | Write qualifier of the C memory; a read when low |
| c_d | output | CW | C write data |
| c_q | input | CW | C read data, valid one cycle after a read |

## Verification
The bench fills C with a nonzero value before every run:
- A design that adds the stale contents at k = 0 would produce every result offset.

An all-minimum pattern makes each sum overflow 16 bits, and a signed ramp against an identity matrix exercises sign extension:
- A design that zero-extends products, or saturates instead of wrapping, would fail these patterns.

Each mode has its run length checked to the exact cycle:
- A schedule that drops a cycle from the three-step read-modify-write sequence, or inserts one, would shift `done`.
- A mistimed forwarding register would either add drain cycles or merge two elements' sums.

A mid-run restart pulse targets a control path that reloads the counters while busy. Such a design would produce a second `done`, a longer run, or corrupted results.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

   // Slot within one read-modify-write k step
   typedef enum logic [1:0] {
      PH_AB = 2'd0,   // issue A and B reads
      PH_C  = 2'd1,   // capture A/B data, issue C read
      PH_WR = 2'd2    // accumulate and write C
   } rmw_ph_t;

   localparam int RMW_SLOTS = 3;

endpackage

// File: rtl/mmx_idx.sv
// Nested index walker: k is innermost, then j, then i.
module mmx_idx #(
   parameter int N  = 5,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   output logic [IW-1:0] i,
   output logic [IW-1:0] j,
   output logic [IW-1:0] k,
   output logic          at_end
);
   localparam logic [IW-1:0] KMAX = IW'(N - 1);

   assign at_end = (i == KMAX) && (j == KMAX) && (k == KMAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i <= '0;
         j <= '0;
         k <= '0;
      end else if (clear) begin
         i <= '0;
         j <= '0;
         k <= '0;
      end else if (step) begin
         if (k == KMAX) begin
            k <= '0;
            if (j == KMAX) begin
               j <= '0;
               i <= (i == KMAX) ? '0 : i + 1'b1;
            end else begin
               j <= j + 1'b1;
            end
         end else begin
            k <= k + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mmx_mac.sv
// Signed multiply, sign-extend to accumulator width, wrap-around add.
module mmx_mac #(
   parameter int EW = 8,
   parameter int CW = 16,
   localparam int PW = 2 * EW
) (
   input  logic [EW-1:0] a,
   input  logic [EW-1:0] b,
   input  logic [CW-1:0] base,
   output logic [CW-1:0] sum
);
   logic signed [PW-1:0] prod;
   logic signed [CW-1:0] prod_x;

   assign prod   = $signed(a) * $signed(b);
   assign prod_x = CW'(prod);
   assign sum    = base + prod_x;
endmodule

// File: rtl/mmx_engine.sv
module mmx_engine
   import mmx_pkg::*;
#(
   parameter int N         = 5,
   parameter int EW        = 8,
   parameter int CW        = 16,
   parameter bit LOCAL_ACC = 1'b0,
   localparam int MAW      = $clog2(N * N),
   localparam int IW       = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic           idle,
   output logic           done,
   output logic [MAW-1:0] a_addr,
   output logic           a_ce,
   input  logic [EW-1:0]  a_q,
   output logic [MAW-1:0] b_addr,
   output logic           b_ce,
   input  logic [EW-1:0]  b_q,
   output logic [MAW-1:0] c_addr,
   output logic           c_ce,
   output logic           c_we,
   output logic [CW-1:0]  c_d,
   input  logic [CW-1:0]  c_q
);
   localparam logic [IW-1:0]  KLAST = IW'(N - 1);
   localparam logic [MAW-1:0] CLAST = MAW'(N * N - 1);

   initial begin
      assert (N >= 2) else $error("mmx_engine: N must be at least 2");
      assert (CW >= 2 * EW) else $error("mmx_engine: CW must hold a full product");
   end

   logic          busy;
   logic          go;
   logic          step;
   logic          at_end;
   logic [IW-1:0] ri, rj, rk;
   logic [MAW-1:0] ik_addr, kj_addr, ij_addr;
   logic [EW-1:0] mac_a, mac_b;
   logic [CW-1:0] mac_base, mac_sum;

   assign idle = !busy;
   assign go   = start && !busy;

   mmx_idx #(.N(N)) u_idx (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (go),
      .step  (step),
      .i     (ri),
      .j     (rj),
      .k     (rk),
      .at_end(at_end)
   );

   assign ik_addr = MAW'(int'(ri) * N + int'(rk));
   assign kj_addr = MAW'(int'(rk) * N + int'(rj));
   assign ij_addr = MAW'(int'(ri) * N + int'(rj));
   assign a_addr  = ik_addr;
   assign b_addr  = kj_addr;

   mmx_mac #(.EW(EW), .CW(CW)) u_mac (
      .a   (mac_a),
      .b   (mac_b),
      .base(mac_base),
      .sum (mac_sum)
   );

   generate
      if (!LOCAL_ACC) begin : g_rmw
         rmw_ph_t       ph;
         logic          run;
         logic          done_r;
         logic [EW-1:0] a_r, b_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run    <= 1'b0;
               ph     <= PH_AB;
               a_r    <= '0;
               b_r    <= '0;
               done_r <= 1'b0;
            end else begin
               done_r <= run && (ph == PH_WR) && at_end;
               if (go) begin
                  run <= 1'b1;
                  ph  <= PH_AB;
               end else if (run) begin
                  case (ph)
                     PH_AB: ph <= PH_C;
                     PH_C: begin
                        ph  <= PH_WR;
                        a_r <= a_q;
                        b_r <= b_q;
                     end
                     default: begin
                        ph <= PH_AB;
                        if (at_end) run <= 1'b0;
                     end
                  endcase
               end
            end
         end

         assign busy     = run;
         assign step     = run && (ph == PH_WR);
         assign a_ce     = run && (ph == PH_AB);
         assign b_ce     = run && (ph == PH_AB);
         assign c_ce     = run && (ph != PH_AB);
         assign c_we     = run && (ph == PH_WR);
         assign c_addr   = ij_addr;
         assign mac_a    = a_r;
         assign mac_b    = b_r;
         assign mac_base = (rk == '0) ? '0 : c_q;
         assign c_d      = mac_sum;
         assign done     = done_r;
      end else begin : g_lacc
         logic           run, v1, first1, last1, wv2, done_r;
         logic [MAW-1:0] cad1, cad2;
         logic [CW-1:0]  acc;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run    <= 1'b0;
               v1     <= 1'b0;
               first1 <= 1'b0;
               last1  <= 1'b0;
               wv2    <= 1'b0;
               done_r <= 1'b0;
               cad1   <= '0;
               cad2   <= '0;
               acc    <= '0;
            end else begin
               if (go) run <= 1'b1;
               else if (run && at_end) run <= 1'b0;
               v1     <= run;
               first1 <= (rk == '0);
               last1  <= (rk == KLAST);
               cad1   <= ij_addr;
               if (v1) acc <= mac_sum;
               wv2    <= v1 && last1;
               cad2   <= cad1;
               done_r <= wv2 && (cad2 == CLAST);
            end
         end

         assign busy     = run || v1 || wv2;
         assign step     = run;
         assign a_ce     = run;
         assign b_ce     = run;
         assign c_ce     = wv2;
         assign c_we     = wv2;
         assign c_addr   = cad2;
         assign mac_a    = a_q;
         assign mac_b    = b_q;
         assign mac_base = first1 ? '0 : acc;
         assign c_d      = acc;
         assign done     = done_r;
      end
   endgenerate
endmodule

// File: rtl/mmx_engine_chk.sv
module mmx_engine_chk #(
   parameter int N         = 5,
   parameter bit LOCAL_ACC = 1'b0,
   parameter int MAW       = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           idle,
   input logic           done,
   input logic           a_ce,
   input logic           b_ce,
   input logic           c_ce,
   input logic           c_we,
   input logic [MAW-1:0] c_addr
);
   localparam logic [MAW-1:0] CLAST = MAW'(N * N - 1);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !(a_ce || b_ce || c_ce)); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(c_ce && c_we && (c_addr == CLAST))); // R4
   AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      c_we |-> c_ce); // R6

   generate
      if (!LOCAL_ACC) begin : g_rmw_chk
         AST_AB_THEN_CRD: assert property (@(posedge clk) disable iff (!rst_n)
            a_ce |=> (!a_ce && c_ce && !c_we)); // R5
         AST_CRD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
            (c_ce && !c_we) |=> (c_ce && c_we)); // R5
      end else begin : g_lacc_chk
         AST_NO_C_READ: assert property (@(posedge clk) disable iff (!rst_n)
            c_ce |-> c_we); // R7
         AST_WR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            c_we |=> !c_we); // R7
      end
   endgenerate
endmodule

bind mmx_engine mmx_engine_chk #(.N(N), .LOCAL_ACC(LOCAL_ACC), .MAW(MAW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .idle  (idle),
   .done  (done),
   .a_ce  (a_ce),
   .b_ce  (b_ce),
   .c_ce  (c_ce),
   .c_we  (c_we),
   .c_addr(c_addr)
);

// File: tb/sim_mmx_engine.sv
module sim_mmx_engine;
   localparam int N    = 5;
   localparam int EW   = 8;
   localparam int CW   = 16;
   localparam int NN   = N * N;
   localparam int N3   = N * N * N;
   localparam int MAW  = $clog2(NN);
   localparam logic [MAW-1:0] CLAST = MAW'(NN - 1);

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [1:0]     start = 2'b00;
   logic [1:0]     idle, done, a_ce, b_ce, c_ce, c_we;
   logic [MAW-1:0] a_addr [2];
   logic [MAW-1:0] b_addr [2];
   logic [MAW-1:0] c_addr [2];
   logic [EW-1:0]  a_q [2];
   logic [EW-1:0]  b_q [2];
   logic [CW-1:0]  c_d [2];
   logic [CW-1:0]  c_q [2];

   logic signed [EW-1:0] amem [NN];
   logic signed [EW-1:0] bmem [NN];
   logic [CW-1:0]        cmem [2][NN];

   int n_chk = 0;
   int n_bad = 0;

   mmx_engine #(.N(N), .EW(EW), .CW(CW), .LOCAL_ACC(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start[0]), .idle(idle[0]), .done(done[0]),
      .a_addr(a_addr[0]), .a_ce(a_ce[0]), .a_q(a_q[0]),
      .b_addr(b_addr[0]), .b_ce(b_ce[0]), .b_q(b_q[0]),
      .c_addr(c_addr[0]), .c_ce(c_ce[0]), .c_we(c_we[0]), .c_d(c_d[0]), .c_q(c_q[0]));

   mmx_engine #(.N(N), .EW(EW), .CW(CW), .LOCAL_ACC(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .start(start[1]), .idle(idle[1]), .done(done[1]),
      .a_addr(a_addr[1]), .a_ce(a_ce[1]), .a_q(a_q[1]),
      .b_addr(b_addr[1]), .b_ce(b_ce[1]), .b_q(b_q[1]),
      .c_addr(c_addr[1]), .c_ce(c_ce[1]), .c_we(c_we[1]), .c_d(c_d[1]), .c_q(c_q[1]));

   // Single-port memory models, one-cycle read latency
   always @(posedge clk) begin
      for (int e = 0; e < 2; e++) begin
         if (a_ce[e]) a_q[e] <= amem[a_addr[e]];
         if (b_ce[e]) b_q[e] <= bmem[b_addr[e]];
         if (c_ce[e]) begin
            if (c_we[e]) cmem[e][c_addr[e]] <= c_d[e];
            else         c_q[e] <= cmem[e][c_addr[e]];
         end
      end
   end

   // Port activity monitor, sampled away from the active edge
   int   n_ab [2];
   int   n_crd [2];
   int   n_cwr [2];
   int   n_done [2];
   int   n_adj [2];
   int   n_seq [2];
   logic prev_ab [2];
   logic prev_last [2];

   always @(negedge clk) begin
      if (rst_n) begin
         for (int e = 0; e < 2; e++) begin
            if (a_ce[e]) n_ab[e]++;
            if (a_ce[e] && prev_ab[e]) n_adj[e]++;
            if (c_ce[e] && !c_we[e]) n_crd[e]++;
            if (c_ce[e] && c_we[e]) n_cwr[e]++;
            if (done[e]) begin
               n_done[e]++;
               if (!prev_last[e]) n_seq[e]++;
            end
            prev_ab[e]   = a_ce[e];
            prev_last[e] = c_ce[e] && c_we[e] && (c_addr[e] == CLAST);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_c(input int r, input int c);
      int s = 0;
      for (int k = 0; k < N; k++) s += int'(amem[r*N+k]) * int'(bmem[k*N+c]);
      return int'(s[CW-1:0]);
   endfunction

   task automatic load_pattern(input int p);
      int seed = 17;
      for (int x = 0; x < NN; x++) begin
         case (p)
            0: begin
               seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
               amem[x] = EW'(seed >> 8);
               seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
               bmem[x] = EW'(seed >> 8);
            end
            1: begin
               amem[x] = -8'sd128;
               bmem[x] = -8'sd128;
            end
            default: begin
               amem[x] = ((x / N) == (x % N)) ? 8'sd1 : 8'sd0;
               bmem[x] = EW'(x * 11 - 128);
            end
         endcase
      end
   endtask

   // Launch one run on engine e; optionally pulse start again mid-run.
   task automatic run_engine(input int e, input bit poke, output int cycles);
      for (int x = 0; x < NN; x++) cmem[e][x] = 16'hBEEF;
      n_ab[e] = 0; n_crd[e] = 0; n_cwr[e] = 0; n_done[e] = 0; n_adj[e] = 0; n_seq[e] = 0;
      @(negedge clk) start[e] = 1'b1;
      @(posedge clk);
      @(negedge clk) start[e] = 1'b0;
      cycles = 0;
      while (1) begin
         @(posedge clk);
         cycles++;
         @(negedge clk);
         if (poke) start[e] = (cycles == 40);
         if (done[e] || cycles > 4000) break;
      end
      start[e] = 1'b0;
      // R9: quiet ports while idle after the run
      for (int w = 0; w < 4; w++) begin
         @(negedge clk);
         chk("R9", "idle flag after done", int'(idle[e]), 1);
         chk("R9", "enables while idle", int'(a_ce[e] | b_ce[e] | c_ce[e]), 0);
      end
   endtask

   task automatic check_result(input int e, input string req);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++)
            chk(req, $sformatf("eng%0d C[%0d][%0d]", e, r, c), int'(cmem[e][r*N+c]), ref_c(r, c));
   endtask

   task automatic check_counts(input int e, input int cycles);
      chk("R4", "done pulses", n_done[e], 1);
      chk("R4", "done not after last write", n_seq[e], 0);
      chk("R6", "A/B read count", n_ab[e], N3);
      if (e == 0) begin
         chk("R5", "rmw cycles to done", cycles, 3 * N3);
         chk("R6", "rmw C reads", n_crd[e], N3);
         chk("R6", "rmw C writes", n_cwr[e], N3);
         chk("R6", "adjacent A/B reads", n_adj[e], 0);
      end else begin
         chk("R7", "local cycles to done", cycles, N3 + 2);
         chk("R7", "local C reads", n_crd[e], 0);
         chk("R7", "local C writes", n_cwr[e], NN);
         chk("R7", "back-to-back A/B reads", n_adj[e], N3 - 1);
      end
   endtask

   task automatic t_reset;
      for (int e = 0; e < 2; e++) begin
         chk("R1", "idle at reset", int'(idle[e]), 1);
         chk("R1", "done at reset", int'(done[e]), 0);
         chk("R1", "enables at reset", int'(a_ce[e] | b_ce[e] | c_ce[e]), 0);
      end
   endtask

   task automatic t_pattern(input int p, input string req);
      int cyc;
      load_pattern(p);
      for (int e = 0; e < 2; e++) begin
         run_engine(e, 1'b0, cyc);
         check_counts(e, cyc);
         check_result(e, req);
      end
   endtask

   task automatic t_busy_start;
      int cyc;
      load_pattern(0);
      for (int e = 0; e < 2; e++) begin
         run_engine(e, 1'b1, cyc);
         chk("R3", "single done with restart pulse", n_done[e], 1);
         chk("R3", "run length with restart pulse", cyc, (e == 0) ? 3 * N3 : N3 + 2);
         check_result(e, "R3");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pattern(0, "R2");   // pseudo-random signed data
      t_pattern(1, "R8");   // all -128: each sum overflows and wraps
      t_pattern(2, "R8");   // identity times signed ramp: sign extension
      t_busy_start();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule